// File: doc/BRIEF.md
# XGMII transmit frame encoder

This block turns a 64-bit packet stream into the 64-bit data and 8-bit control words of a 10 Gb/s XGMII transmit interface. For each packet it emits one header word (start control character, six preamble bytes and the start-of-frame delimiter), then the payload with its byte order reversed into XGMII lane order. A CRC-32 frame check sequence follows the payload, then a terminate character, then idle characters for the interframe gap. The footer begins in the unused lanes of the final payload word and continues into the next word.

The stream side is valid/ready. A word is taken on a rising edge where both `s_valid` and `s_ready` are high. There is no transmit buffer, so back-pressure is limited to two rules. First, `s_ready` falls for a fixed number of cycles after every end-of-packet word, which makes room for the header and footer. Second, it stays low between packets while `link_up` is low. Once the first word of a packet is taken, `s_ready` stays high until the end-of-packet word. The source must then present a valid word on every cycle, with no gaps. Frames shorter than the Ethernet minimum are sent exactly as given; padding is the source's job.

`link_up` is a plain level input from the receive side. Control characters are 0x07 for idle, 0xFB for start, 0xFD for terminate, 0x55 for preamble and 0xD5 for the delimiter.

Top module: `xgmii_tx_framer`

## Requirements
- R1: Whenever no frame content is due, every lane of `xgmii_txd` carries 0x07 and every bit of `xgmii_txc` is 1. This includes the cycles during and after reset.
- R2: Between packets, `s_ready` is low while `link_up` is low. It is high when `link_up` is high and no post-packet gap is pending.
- R3: If the first word of a packet is taken on edge k, the cycle after edge k+1 shows the header word 0xD5555555555555FB with `xgmii_txc` = 0x01. The start character is in lane 0 (bits 7:0) and the delimiter in lane 7. The cycle after edge k+2 shows that first payload word.
- R4: Stream byte i (bits 63-8i down to 56-8i) goes out on XGMII lane i (bits 8i+7 down to 8i). Any output word that carries only payload has `xgmii_txc` = 0x00.
- R5: On the end-of-packet word, `s_empty` = E (0 to 7) means that only the top 8-E stream bytes are payload. They occupy lanes 0 to 7-E, and the footer starts in lane 8-E.
- R6: The four bytes right after the payload are the frame check sequence, least significant byte first, each with control bit 0. It is CRC-32 (generator 0x04C11DB7, processed LSB first, seed all ones, result inverted) over the payload bytes only. For the payload "123456789" the bytes are 0x26, 0x39, 0xF4, 0xCB.
- R7: The frame check sequence is followed by 0xFD with control bit 1, and then by idles. When the next packet is offered as soon as `s_ready` returns, exactly E+11 idle bytes separate the terminate character from the next start character.
- R8: After the end-of-packet word is taken, `s_ready` is low for exactly 3 cycles and then returns high, provided `link_up` is high.
- R9: After the first word of a packet is taken, `s_ready` stays high until the end-of-packet word is taken, even if `link_up` falls.
- R10: While `s_valid` is low, the values on `s_data`, `s_empty` and `s_last` have no effect on the XGMII output.
- R11: A packet of any length, including one under 60 bytes, is sent with exactly its own payload bytes and no padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, shared with the XGMII interface |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 1 | Receive side reports link up; gates new packets |
| s_data | input | 64 | Stream word, first byte in bits 63:56 |
| s_empty | input | 3 | Unused byte count of the end-of-packet word |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Marks the end-of-packet word |
| s_ready | output | 1 | Block accepts the stream word this cycle |
| xgmii_txd | output | 64 | XGMII transmit data, lane 0 in bits 7:0 |
| xgmii_txc | output | 8 | XGMII transmit control, one bit per lane |

## Verification
The bench uses the default parameters: eight lanes and a three-cycle ready gap. With these values, a full final word leaves exactly eleven idle bytes before the next start. A back-to-back burst of lengths 64 to 72 therefore covers every `s_empty` value, including this tightest gap, and checks each idle count exactly. A nine-byte packet compares the frame check sequence against a known value and shows that short frames go out unpadded. A link drop in the middle of a packet shows that `s_ready` holds high through the packet and then stays low.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;

  localparam logic [7:0]  XG_IDLE     = 8'h07;
  localparam logic [7:0]  XG_START    = 8'hFB;
  localparam logic [7:0]  XG_TERM     = 8'hFD;
  localparam logic [7:0]  XG_PREAMBLE = 8'h55;
  localparam logic [7:0]  XG_SFD      = 8'hD5;

  // Reflected form of generator 0x04C11DB7
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam int          FCS_BYTES     = 4;

  typedef struct packed {
    logic       ctl;
    logic [7:0] val;
  } xg_lane_t;

  localparam xg_lane_t LANE_IDLE = '{ctl: 1'b1, val: XG_IDLE};

  // One byte into the running CRC, least significant bit first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  // Byte idx of the footer: check sequence, terminate, then idles
  function automatic xg_lane_t tail_lane(input logic [5:0] idx, input logic [31:0] fcs);
    xg_lane_t l;
    if (int'(idx) < FCS_BYTES) begin
      l = '{ctl: 1'b0, val: fcs[{idx[1:0], 3'b000} +: 8]};
    end else if (int'(idx) == FCS_BYTES) begin
      l = '{ctl: 1'b1, val: XG_TERM};
    end else begin
      l = LANE_IDLE;
    end
    return l;
  endfunction

endpackage

// File: rtl/xgtx_crc.sv
module xgtx_crc #(
  parameter int LANES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         restart,
  input  logic [8*LANES-1:0]           data,
  input  logic [$clog2(LANES+1)-1:0]   nbytes,
  output logic [31:0]                  crc_q
);
  import xgtx_pkg::*;

  localparam int DW = 8 * LANES;

  logic [31:0] crc_next;

  // Bytes taken from the top of the word, up to nbytes of them
  always_comb begin
    logic [31:0] acc;
    acc = restart ? CRC_SEED : crc_q;
    for (int i = 0; i < LANES; i++) begin
      if (i < int'(nbytes)) begin
        acc = crc32_byte(acc, data[DW-1-8*i -: 8]);
      end
    end
    crc_next = acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (en) begin
      crc_q <= crc_next;
    end
  end

endmodule

// File: rtl/xgtx_flow.sv
module xgtx_flow #(
  parameter int GAP_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic s_valid,
  input  logic s_last,
  output logic s_ready,
  output logic first_beat
);
  localparam int CW = $clog2(GAP_CYCLES + 1);

  logic          open_q;
  logic [CW-1:0] gap_q;
  logic          take;

  assign s_ready    = open_q | (link_up & (gap_q == '0));
  assign first_beat = ~open_q;
  assign take       = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      gap_q  <= '0;
    end else if (take) begin
      open_q <= ~s_last;
      if (s_last) begin
        gap_q <= CW'(GAP_CYCLES);
      end
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

endmodule

// File: rtl/xgtx_lane_mux.sv
module xgtx_lane_mux #(
  parameter int LANES = 8
) (
  input  logic                       hdr_req,
  input  logic                       dat_vld,
  input  logic [8*LANES-1:0]         dat_word,
  input  logic [$clog2(LANES+1)-1:0] dat_nb,
  input  logic                       ftr_req,
  input  logic [$clog2(LANES+1)-1:0] ftr_off,
  input  logic [31:0]                fcs_now,
  input  logic [31:0]                fcs_held,
  output logic [8*LANES-1:0]         nxt_txd,
  output logic [LANES-1:0]           nxt_txc
);
  import xgtx_pkg::*;

  localparam int DW = 8 * LANES;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      xg_lane_t l;
      l = LANE_IDLE;
      if (dat_vld) begin
        if (j < int'(dat_nb)) begin
          l = '{ctl: 1'b0, val: dat_word[DW-1-8*j -: 8]};
        end else begin
          l = tail_lane(6'(j - int'(dat_nb)), fcs_now);
        end
      end else if (ftr_req) begin
        l = tail_lane(6'(j + int'(ftr_off)), fcs_held);
      end else if (hdr_req) begin
        if (j == 0) begin
          l = '{ctl: 1'b1, val: XG_START};
        end else if (j == LANES - 1) begin
          l = '{ctl: 1'b0, val: XG_SFD};
        end else begin
          l = '{ctl: 1'b0, val: XG_PREAMBLE};
        end
      end
      nxt_txc[j]         = l.ctl;
      nxt_txd[8*j +: 8]  = l.val;
    end
  end

endmodule

// File: rtl/xgmii_tx_framer.sv
module xgmii_tx_framer #(
  parameter int LANES      = 8,
  parameter int GAP_CYCLES = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       link_up,
  input  logic [8*LANES-1:0]         s_data,
  input  logic [$clog2(LANES)-1:0]   s_empty,
  input  logic                       s_valid,
  input  logic                       s_last,
  output logic                       s_ready,
  output logic [8*LANES-1:0]         xgmii_txd,
  output logic [LANES-1:0]           xgmii_txc
);
  import xgtx_pkg::*;

  localparam int DW  = 8 * LANES;
  localparam int NBW = $clog2(LANES + 1);

  logic           first_beat;
  logic           take;
  logic [NBW-1:0] in_nb;

  // Stage 1: accepted word, CRC input
  logic           s1_vld, s1_sof, s1_last;
  logic [DW-1:0]  s1_data;
  logic [NBW-1:0] s1_nb;
  // Stage 2: word waiting behind the header slot
  logic           s2_vld, s2_last;
  logic [DW-1:0]  s2_data;
  logic [NBW-1:0] s2_nb;
  // Footer spill into the word after the last payload word
  logic           ftr_pend;
  logic [NBW-1:0] ftr_off;
  logic [31:0]    fcs_held;

  logic [31:0]    crc_q;
  logic [31:0]    fcs_now;
  logic [DW-1:0]  nxt_txd;
  logic [LANES-1:0] nxt_txc;

  xgtx_flow #(.GAP_CYCLES(GAP_CYCLES)) flow_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_up    (link_up),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .first_beat (first_beat)
  );

  assign take  = s_valid & s_ready;
  assign in_nb = s_last ? (NBW'(LANES) - NBW'(s_empty)) : NBW'(LANES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_sof  <= 1'b0;
      s1_last <= 1'b0;
      s1_data <= '0;
      s1_nb   <= '0;
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
      s2_data <= '0;
      s2_nb   <= '0;
    end else begin
      s1_vld <= take;
      s1_sof <= take & first_beat;
      if (take) begin
        s1_last <= s_last;
        s1_data <= s_data;
        s1_nb   <= in_nb;
      end
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_last <= s1_last;
        s2_data <= s1_data;
        s2_nb   <= s1_nb;
      end
    end
  end

  xgtx_crc #(.LANES(LANES)) crc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (s1_vld),
    .restart (s1_sof),
    .data    (s1_data),
    .nbytes  (s1_nb),
    .crc_q   (crc_q)
  );

  assign fcs_now = ~crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftr_pend <= 1'b0;
      ftr_off  <= '0;
      fcs_held <= '0;
    end else begin
      ftr_pend <= s2_vld & s2_last;
      if (s2_vld && s2_last) begin
        ftr_off  <= NBW'(LANES) - s2_nb;
        fcs_held <= fcs_now;
      end
    end
  end

  xgtx_lane_mux #(.LANES(LANES)) mux_i (
    .hdr_req  (s1_vld & s1_sof),
    .dat_vld  (s2_vld),
    .dat_word (s2_data),
    .dat_nb   (s2_nb),
    .ftr_req  (ftr_pend),
    .ftr_off  (ftr_off),
    .fcs_now  (fcs_now),
    .fcs_held (fcs_held),
    .nxt_txd  (nxt_txd),
    .nxt_txc  (nxt_txc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xgmii_txd <= {LANES{XG_IDLE}};
      xgmii_txc <= '1;
    end else begin
      xgmii_txd <= nxt_txd;
      xgmii_txc <= nxt_txc;
    end
  end

endmodule

// File: rtl/xgtx_tx_checker.sv
module xgtx_tx_checker #(
  parameter int LANES      = 8,
  parameter int GAP_CYCLES = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 link_up,
  input logic                 s_valid,
  input logic                 s_last,
  input logic                 s_ready,
  input logic [8*LANES-1:0]   xgmii_txd,
  input logic [LANES-1:0]     xgmii_txc
);
  logic       acc;
  logic       open_q;
  logic [7:0] since_q;

  assign acc = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      since_q <= '0;
    end else begin
      if (acc) open_q <= ~s_last;
      if (acc && s_last) since_q <= 8'd1;
      else if (since_q != 0 && since_q != 8'hFF) since_q <= since_q + 8'd1;
    end
  end

  // R8
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != 0 && int'(since_q) <= GAP_CYCLES && !acc) |-> !s_ready);

  // R8
  gap_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_q) == GAP_CYCLES + 1 && link_up) |-> s_ready);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> s_ready);

  // R2
  link_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !link_up) |-> !s_ready);

  // R3
  header_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && !open_q) |=> (xgmii_txc == LANES'(1) && xgmii_txd[7:0] == 8'hFB));

  // R3
  start_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xgmii_txc[0] && xgmii_txd[7:0] == 8'hFB) |-> xgmii_txc == LANES'(1));

  // R4
  data_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && !s_last, 2) |=> xgmii_txc == '0);

endmodule

bind xgmii_tx_framer xgtx_tx_checker #(.LANES(LANES), .GAP_CYCLES(GAP_CYCLES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_up   (link_up),
  .s_valid   (s_valid),
  .s_last    (s_last),
  .s_ready   (s_ready),
  .xgmii_txd (xgmii_txd),
  .xgmii_txc (xgmii_txc)
);

// File: tb/xgmii_tx_framer_tb_top.sv
module xgmii_tx_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic [63:0] s_data = '0;
  logic [2:0]  s_empty = '0;
  logic        s_valid = 1'b0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic [63:0] xgmii_txd;
  logic [7:0]  xgmii_txc;

  int nchk = 0;
  int nfail = 0;

  logic [8:0]   cap_q[$];
  bit           cap_en = 1'b0;
  byte unsigned exp_b[$];
  int           exp_len[$];
  int           exp_e[$];
  bit           exp_follow[$];

  always #4 clk = ~clk;

  xgmii_tx_framer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .s_data    (s_data),
    .s_empty   (s_empty),
    .s_valid   (s_valid),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .xgmii_txd (xgmii_txd),
    .xgmii_txc (xgmii_txc)
  );

  always @(negedge clk) begin
    if (cap_en) begin
      for (int l = 0; l < 8; l++) cap_q.push_back({xgmii_txc[l], xgmii_txd[8*l +: 8]});
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Check sequence: MSB-first register, bits fed LSB first, reflected at the end
  function automatic logic [31:0] ref_fcs(input byte unsigned b[$], input int from, input int n);
    logic [31:0] r;
    logic [31:0] o;
    logic        fb;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < 8; j++) begin
        fb = r[31] ^ b[from+i][j];
        r  = {r[30:0], 1'b0};
        if (fb) r = r ^ 32'h04C1_1DB7;
      end
    end
    for (int k = 0; k < 32; k++) o[k] = ~r[31-k];
    return o;
  endfunction

  task automatic send_pkt(input byte unsigned pl[$], input bit drop_mid, input bit follow);
    int n;
    int nw;
    int lowc;
    n  = pl.size();
    nw = (n + 7) / 8;
    foreach (pl[i]) exp_b.push_back(pl[i]);
    exp_len.push_back(n);
    exp_e.push_back(8 * nw - n);
    exp_follow.push_back(follow);
    for (int w = 0; w < nw; w++) begin
      logic [63:0] d;
      int cnt;
      d   = '0;
      cnt = (w == nw - 1) ? n - 8 * w : 8;
      for (int b = 0; b < cnt; b++) d[63-8*b -: 8] = pl[8*w+b];
      if (w > 0) @(negedge clk);
      if (drop_mid && w == 1) link_up = 1'b0;
      s_valid = 1'b1;
      s_data  = d;
      s_last  = (w == nw - 1);
      s_empty = 3'(8 - cnt);
      if (w == 0) begin
        while (!s_ready) @(negedge clk);
      end else begin
        chk(s_ready == 1'b1, "R9", "ready mid packet", 64'(s_ready), 64'd1);
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    lowc = 0;
    while (!s_ready && lowc < 10) begin
      lowc++;
      @(negedge clk);
    end
    if (!drop_mid) chk(lowc == 3, "R8", "ready low cycles after end", 64'(lowc), 64'd3);
  endtask

  task automatic begin_cap();
    cap_q.delete();
    exp_b.delete();
    exp_len.delete();
    exp_e.delete();
    exp_follow.delete();
    cap_en = 1'b1;
  endtask

  task automatic end_cap_parse(input string pl_tag);
    int p;
    int off;
    int cnt;
    bit ok;
    logic [31:0] fcs;
    repeat (6) @(negedge clk);
    cap_en = 1'b0;
    p   = 0;
    off = 0;
    foreach (exp_len[k]) begin
      while (p < cap_q.size() && cap_q[p] == 9'h107) p++;
      ok = (p + 8 <= cap_q.size()) && (p % 8 == 0) && (cap_q[p] == 9'h1FB);
      for (int i = 1; i < 7; i++) if (ok && cap_q[p+i] != 9'h055) ok = 1'b0;
      if (ok && cap_q[p+7] != 9'h0D5) ok = 1'b0;
      chk(ok, "R3", "header bytes", 64'(p), 64'(p));
      p += 8;
      ok = (p + exp_len[k] + 5 <= cap_q.size());
      for (int i = 0; ok && i < exp_len[k]; i++) begin
        if (cap_q[p+i] != {1'b0, exp_b[off+i]}) begin
          ok = 1'b0;
          chk(1'b0, pl_tag, "payload byte", 64'(cap_q[p+i]), 64'({1'b0, exp_b[off+i]}));
        end
      end
      if (ok) chk(1'b1, pl_tag, "payload", 0, 0);
      if (!ok) break;
      p += exp_len[k];
      fcs = ref_fcs(exp_b, off, exp_len[k]);
      chk({cap_q[p+3], cap_q[p+2], cap_q[p+1], cap_q[p]} ==
          {1'b0, fcs[31:24], 1'b0, fcs[23:16], 1'b0, fcs[15:8], 1'b0, fcs[7:0]},
          "R6", "check sequence",
          64'({cap_q[p+3][7:0], cap_q[p+2][7:0], cap_q[p+1][7:0], cap_q[p][7:0]}), 64'(fcs));
      p += 4;
      chk(cap_q[p] == 9'h1FD, "R7", "terminate", 64'(cap_q[p]), 64'h1FD);
      p++;
      cnt = 0;
      while (p < cap_q.size() && cap_q[p] == 9'h107) begin
        cnt++;
        p++;
      end
      if (k + 1 < exp_len.size() && exp_follow[k+1]) begin
        chk(cnt == exp_e[k] + 11, "R7", "idle bytes before next start", 64'(cnt), 64'(exp_e[k] + 11));
      end else begin
        chk(cnt >= 11, "R7", "idle bytes after frame", 64'(cnt), 64'd11);
      end
      off += exp_len[k];
    end
  endtask

  task automatic t_reset();
    rst_n   = 1'b0;
    link_up = 1'b0;
    repeat (3) @(negedge clk);
    chk(xgmii_txd == {8{8'h07}} && xgmii_txc == 8'hFF, "R1", "idle in reset", xgmii_txd, {8{8'h07}});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(xgmii_txd == {8{8'h07}} && xgmii_txc == 8'hFF, "R1", "idle after reset", xgmii_txd, {8{8'h07}});
    chk(s_ready == 1'b0, "R2", "ready with link down", 64'(s_ready), 64'd0);
    link_up = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R2", "ready with link up", 64'(s_ready), 64'd1);
  endtask

  task automatic t_latency();
    byte unsigned pl[$];
    logic [31:0] fcs;
    for (int i = 0; i < 8; i++) pl.push_back(byte'(8'h11 * i));
    fcs = ref_fcs(pl, 0, 8);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_data  = 64'h0011_2233_4455_6677;
    s_last  = 1'b1;
    s_empty = 3'd0;
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    chk(s_ready == 1'b0, "R8", "ready low cycle 1", 64'(s_ready), 64'd0);
    @(negedge clk);
    chk(xgmii_txd == 64'hD555_5555_5555_55FB && xgmii_txc == 8'h01, "R3", "header word",
        xgmii_txd, 64'hD555_5555_5555_55FB);
    chk(s_ready == 1'b0, "R8", "ready low cycle 2", 64'(s_ready), 64'd0);
    @(negedge clk);
    chk(xgmii_txd == 64'h7766_5544_3322_1100, "R4", "lane order of payload word",
        xgmii_txd, 64'h7766_5544_3322_1100);
    chk(xgmii_txc == 8'h00, "R4", "payload control bits", 64'(xgmii_txc), 64'h00);
    chk(s_ready == 1'b0, "R8", "ready low cycle 3", 64'(s_ready), 64'd0);
    @(negedge clk);
    chk(xgmii_txd == {8'h07, 8'h07, 8'h07, 8'hFD, fcs[31:24], fcs[23:16], fcs[15:8], fcs[7:0]},
        "R6", "footer word", xgmii_txd,
        {8'h07, 8'h07, 8'h07, 8'hFD, fcs[31:24], fcs[23:16], fcs[15:8], fcs[7:0]});
    chk(xgmii_txc == 8'hF0, "R7", "footer control bits", 64'(xgmii_txc), 64'hF0);
    chk(s_ready == 1'b1, "R8", "ready back", 64'(s_ready), 64'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_known_short();
    byte unsigned pl[$];
    string s;
    s = "123456789";
    for (int i = 0; i < s.len(); i++) pl.push_back(byte'(s[i]));
    chk(ref_fcs(pl, 0, 9) == 32'hCBF4_3926, "R6", "known check value", 64'(ref_fcs(pl, 0, 9)), 64'hCBF4_3926);
    begin_cap();
    @(negedge clk);
    send_pkt(pl, 1'b0, 1'b0);
    end_cap_parse("R11");
  endtask

  task automatic t_burst();
    begin_cap();
    @(negedge clk);
    for (int len = 64; len <= 72; len++) begin
      byte unsigned pl[$];
      for (int i = 0; i < len; i++) pl.push_back(byte'((len * 7 + i) & 8'hFF));
      send_pkt(pl, 1'b0, len != 64);
    end
    end_cap_parse("R5");
  endtask

  task automatic t_valid_low();
    bit ok;
    begin_cap();
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b1;
    s_empty = 3'd5;
    for (int i = 0; i < 12; i++) begin
      s_data = {32'hDEAD_BEEF, 32'(i)};
      @(negedge clk);
    end
    s_last = 1'b0;
    repeat (4) @(negedge clk);
    cap_en = 1'b0;
    ok = 1'b1;
    foreach (cap_q[i]) if (cap_q[i] != 9'h107) ok = 1'b0;
    chk(ok, "R10", "output idle with valid low", 64'(cap_q.size()), 64'(cap_q.size()));
    chk(s_ready == 1'b1, "R10", "ready unaffected", 64'(s_ready), 64'd1);
  endtask

  task automatic t_link_drop();
    byte unsigned pl[$];
    for (int i = 0; i < 20; i++) pl.push_back(byte'(8'hA0 + i));
    begin_cap();
    @(negedge clk);
    send_pkt(pl, 1'b1, 1'b0);
    chk(s_ready == 1'b0, "R2", "ready held off after link drop", 64'(s_ready), 64'd0);
    end_cap_parse("R9");
    link_up = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R2", "ready after link returns", 64'(s_ready), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_known_short();
    t_burst();
    t_valid_low();
    t_link_drop();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule